// File: doc/BRIEF.md
# I2C Slave Auto-Acknowledge Responder

This block is the slave side of a two-wire serial bus. It samples SCL and SDA through synchronizers and glitch filters, detects START, repeated START and STOP, and compares the first byte of each transfer with a programmable 7-bit own address. On a match it becomes busy and acknowledges by itself. No input can suppress that acknowledge. It then either receives data bytes from the master or sends bytes that the surrounding logic supplies on `tx_data`.

Received bytes appear on a held output register, marked by a one-cycle strobe. In the transmit direction a one-cycle strobe reports each time a byte has been taken from `tx_data`. A master NAK after a transmitted byte marks the last byte. The block then releases SDA and stays busy until the master closes the transfer with a STOP or a repeated START. The block drives SDA only as an open-drain pull-down: `sda_oe` high means the line is pulled low. General call, 10-bit addressing and clock stretching are not provided.

Top module: `i2c_slv_responder`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A STOP returns the block to idle with `busy` low and SDA released.
- R2: When the 7 address bits (MSB first, followed by the direction bit, 1 = master reads) equal `own_addr`, the block acknowledges in the ninth clock and sets `busy`. Nothing can suppress this acknowledge.
- R3: The acknowledge is asserted after the SCL fall that ends the eighth bit, is held through the ninth SCL high phase, and is released after the SCL fall that ends the ninth pulse. `sda_oe` changes only while filtered SCL is low.
- R4: On a non-matching address, the block neither acknowledges nor drives SDA until the next START.
- R5: In slave-receive, every data byte is acknowledged. The byte (first bit = MSB) is then available on `rx_data`, and `rx_valid` pulses once.
- R6: In slave-transmit, the block loads `tx_data` at the SCL fall that ends an acknowledge slot, either its own address acknowledge or a master ACK. It then shifts the byte out MSB first and pulses `tx_req` once per load.
- R7: A master NAK (SDA high in the ninth clock) after a transmitted byte pulses `nak_seen` and releases SDA. `busy` stays high until a STOP or a repeated START is seen.
- R8: A repeated START clears `busy` and restarts address matching, so a following matching address is acknowledged again.
- R9: A pulse on SDA or SCL shorter than `FILT_LEN` clock cycles has no effect. For example, a short high blip on SDA while SCL is high is not taken as a STOP.
- R10: After reset `sda_oe`, `busy`, `rx_valid`, `tx_req`, `addr_hit` and `nak_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| own_addr | input | 7 | Slave address to respond to |
| tx_data | input | 8 | Next byte to send when the master reads |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Addressed and transfer not yet closed |
| rd_mode | output | 1 | Direction bit of the current transfer |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| tx_req | output | 1 | One-cycle strobe when `tx_data` was taken |
| addr_hit | output | 1 | One-cycle strobe on an own-address match |
| nak_seen | output | 1 | One-cycle strobe on the master's final NAK |

## Verification
Each bus edge reaches the engine after 2 synchronizer stages, `FILT_LEN` filter stages and the filter output register. With the defaults that is about 7 clock cycles, and the outputs change on the following edge. The bench master holds every SCL and SDA phase for 16 clock cycles. It samples the wired line and `sda_oe` in the middle of each SCL high phase, by which time any response to the preceding SCL fall has settled. It checks `busy` 16 cycles after a STOP or repeated START. The glitch test holds its pulse one cycle shorter than the filter window and checks `busy` a full phase later.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_HOLD
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_filt.sv
module i2c_slv_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_MSB-1:0], raw};
  end

  generate
    if (FILT_LEN < 2) begin : g_nofilt
      always_ff @(posedge clk) begin
        if (rst) filt <= 1'b1;
        else     filt <= sync_q[SYNC_MSB];
      end
    end else begin : g_filt
      logic [FILT_LEN-1:0] win_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          win_q <= '1;
          filt  <= 1'b1;
        end else begin
          win_q <= {win_q[FILT_LEN-2:0], sync_q[SYNC_MSB]};
          if (&win_q)       filt <= 1'b1;
          else if (~|win_q) filt <= 1'b0;
        end
      end
      // a new filtered level must match what the synchronizer delivered earlier
      AST_FILT_AGREES: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt) |-> ($past(sync_q[SYNC_MSB], 2) == filt)); // R9
    end
  endgenerate
endmodule

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    scl_rise = scl_f & ~scl_q;
    scl_fall = ~scl_f & scl_q;
    start_ev = scl_q & scl_f & sda_q & ~sda_f;
    stop_ev  = scl_q & scl_f & ~sda_q & sda_f;
  end
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              busy,
  output logic              rd_mode,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_req,
  output logic              addr_hit,
  output logic              nak_seen
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  slv_state_e        state_q;
  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full_q;
  logic              mack_q;

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    tx_req   <= 1'b0;
    addr_hit <= 1'b0;
    nak_seen <= 1'b0;
    if (rst) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      rd_mode <= 1'b0;
      rx_data <= '0;
    end else if (start_ev) begin
      state_q <= ST_ADDR;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_f};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) full_q <= 1'b1;
          end else if (scl_fall && full_q) begin
            full_q <= 1'b0;
            if (state_q == ST_RX) begin
              rx_data  <= sh_q;
              rx_valid <= 1'b1;
              sda_oe   <= 1'b1;
              state_q  <= ST_RX_ACK;
            end else if (sh_q[DATA_W-1:1] == own_addr) begin
              sda_oe   <= 1'b1;
              busy     <= 1'b1;
              addr_hit <= 1'b1;
              rd_mode  <= sh_q[0];
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rd_mode) begin
              sh_q    <= tx_data;
              sda_oe  <= ~tx_data[DATA_W-1];
              tx_req  <= 1'b1;
              state_q <= ST_TX;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            state_q <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              sda_oe  <= 1'b0;
              cnt_q   <= '0;
              mack_q  <= 1'b0;
              state_q <= ST_TX_ACK;
            end else begin
              sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
              sda_oe <= ~sh_q[DATA_W-2];
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_f) begin
              nak_seen <= 1'b1;
              state_q  <= ST_HOLD;
            end else begin
              mack_q <= 1'b1;
            end
          end else if (scl_fall && mack_q) begin
            sh_q    <= tx_data;
            sda_oe  <= ~tx_data[DATA_W-1];
            tx_req  <= 1'b1;
            state_q <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ADDR_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADDR_ACK) |-> sda_oe); // R2
  AST_DATA_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX_ACK) |-> sda_oe); // R5
  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_f); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!sda_oe && !busy)); // R4
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> (busy && !sda_oe)); // R7
  AST_HIT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    addr_hit |-> busy); // R2
endmodule

// File: rtl/i2c_slv_responder.sv
module i2c_slv_responder #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DATA_W-2:0] own_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              sda_oe,
  output logic              busy,
  output logic              rd_mode,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_req,
  output logic              addr_hit,
  output logic              nak_seen
);
  logic scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_slv_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_scl_filt (
    .clk(clk), .rst(rst), .raw(scl_i), .filt(scl_f));

  i2c_slv_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sda_filt (
    .clk(clk), .rst(rst), .raw(sda_i), .filt(sda_f));

  i2c_slv_cond i_cond (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev));

  i2c_slv_engine #(.DATA_W(DATA_W)) i_engine (
    .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .own_addr(own_addr), .tx_data(tx_data),
    .sda_oe(sda_oe), .busy(busy), .rd_mode(rd_mode),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_req(tx_req),
    .addr_hit(addr_hit), .nak_seen(nak_seen));
endmodule

// File: tb/test_i2c_slv_responder.sv
`timescale 1ns/1ps
module test_i2c_slv_responder;
  localparam int Q = 16;
  localparam logic [6:0] OWN = 7'h3A;
  // {expect_ack, address[6:0], data[7:0]}
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 7'h3A, 8'h5C},
    {1'b1, 7'h3A, 8'hA3},
    {1'b0, 7'h3B, 8'h11},
    {1'b1, 7'h3A, 8'h00},
    {1'b1, 7'h3A, 8'hFF},
    {1'b0, 7'h1A, 8'h80}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, busy, rd_mode, rx_valid, tx_req, addr_hit, nak_seen;
  logic [7:0] rx_data;
  logic sda_line;
  int n_tests = 0;
  int n_fail  = 0;
  int rxv_cnt = 0;
  int txr_cnt = 0;
  int nak_cnt = 0;
  bit done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_slv_responder i_i2c_slv_responder (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .own_addr(OWN), .tx_data(tx_data),
    .sda_oe(sda_oe), .busy(busy), .rd_mode(rd_mode),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_req(tx_req),
    .addr_hit(addr_hit), .nak_seen(nak_seen));

  always @(posedge clk) begin
    if (rx_valid) rxv_cnt <= rxv_cnt + 1;
    if (tx_req)   txr_cnt <= txr_cnt + 1;
    if (nak_seen) nak_cnt <= nak_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(Q);
  endtask

  // one bit: drive b, sample the line and sda_oe mid-high
  task automatic bit_io(input logic b, output logic line, output logic oe);
    sda_m = b; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    line = sda_line; oe = sda_oe;
    wait_clk(Q);
    scl_m = 1'b0; wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_line,
                           output logic oe8, output logic oe9);
    logic l, o;
    for (int i = 7; i >= 0; i--) begin
      bit_io(v[i], l, o);
      if (i == 0) oe8 = o;
    end
    bit_io(1'b1, ack_line, oe9);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] v);
    logic l, o;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, l, o);
      v[i] = l;
    end
    bit_io(master_ack, l, o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R10: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack, oe8, oe9;
    logic [7:0] rv;
    int rx0, tx0, nk0;

    wait_clk(5);
    // R10 reset state
    check("R10 sda_oe", sda_oe, 0);
    check("R10 busy", busy, 0);
    check("R10 strobes", {rx_valid, tx_req, addr_hit, nak_seen}, 0);
    rst = 1'b0;
    wait_clk(Q);

    // table of write transfers: R2 R3 R4 R5 R1
    for (int k = 0; k < NVEC; k++) begin
      logic ea;
      logic [6:0] ad;
      logic [7:0] dv;
      {ea, ad, dv} = VEC[k];
      rx0 = rxv_cnt;
      bus_start();
      send_byte({ad, 1'b0}, ack, oe8, oe9);
      check(ea ? "R2 address ack" : "R4 no address ack", ack, !ea);
      check("R2 busy after address", busy, ea);
      send_byte(dv, ack, oe8, oe9);
      check(ea ? "R5 data ack" : "R4 no data ack", ack, !ea);
      check("R3 released during bit 8", oe8, 0);
      check("R3 ack held in ninth clock", oe9, ea);
      wait_clk(Q);
      check("R3 ack released after ninth", sda_oe, 0);
      if (ea) begin
        check("R5 rx_data", rx_data, dv);
        check("R5 one rx_valid", rxv_cnt - rx0, 1);
      end
      bus_stop();
      wait_clk(Q);
      check("R1 busy cleared by STOP", busy, 0);
    end

    // slave-transmit with final NAK then STOP: R6 R7
    tx0 = txr_cnt; nk0 = nak_cnt;
    tx_data = 8'hA5;
    bus_start();
    send_byte({OWN, 1'b1}, ack, oe8, oe9);
    check("R2 read address ack", ack, 0);
    check("R6 first load", txr_cnt - tx0, 1);
    tx_data = 8'h3C;
    recv_byte(1'b0, rv);
    check("R6 first byte", rv, 8'hA5);
    recv_byte(1'b1, rv);
    check("R6 second byte", rv, 8'h3C);
    check("R6 two loads", txr_cnt - tx0, 2);
    check("R7 nak_seen once", nak_cnt - nk0, 1);
    wait_clk(3 * Q);
    check("R7 busy held after NAK", busy, 1);
    check("R7 SDA released after NAK", sda_oe, 0);
    bus_stop();
    wait_clk(Q);
    check("R7 busy cleared by STOP", busy, 0);

    // NAK then repeated START: R8
    tx_data = 8'h96;
    bus_start();
    send_byte({OWN, 1'b1}, ack, oe8, oe9);
    recv_byte(1'b1, rv);
    check("R6 byte before Sr", rv, 8'h96);
    check("R7 busy before Sr", busy, 1);
    bus_rstart();
    check("R8 busy cleared by Sr", busy, 0);
    send_byte({OWN, 1'b0}, ack, oe8, oe9);
    check("R8 address ack after Sr", ack, 0);
    send_byte(8'h4E, ack, oe8, oe9);
    check("R8 data after Sr", rx_data, 8'h4E);
    bus_stop();
    wait_clk(Q);

    // glitch on SDA while SCL high must not read as STOP: R9
    bus_start();
    send_byte({OWN, 1'b0}, ack, oe8, oe9);
    sda_m = 1'b0; wait_clk(Q);
    scl_m = 1'b1; wait_clk(Q);
    sda_m = 1'b1; wait_clk(3);
    sda_m = 1'b0; wait_clk(Q);
    check("R9 SDA glitch ignored", busy, 1);
    scl_m = 1'b0; wait_clk(Q);
    bus_stop();
    wait_clk(Q);
    check("R1 STOP after glitch test", busy, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule